// File: doc/BRIEF.md
# Dual Wiper Register Two-Wire Slave

This block is a two-wire bus slave that keeps two 8-bit wiper position registers for a pair of digitally set potentiometers. A bus master writes the registers through a command byte and reads them back in a fixed order. The block works on a fast system clock. It passes SCL and SDA through synchronizers and finds bus edges, START and STOP in that clock domain. It drives SDA only through a single output enable for an open-drain pad.

A transfer opens with a control byte. Its top four bits are a fixed device code 0101. The next three bits must equal the live, synchronized address pins, and the last bit picks read (1) or write (0). In a write, the next byte is a command that steers the data bytes after it into one or both wipers. In a read, the slave sends wiper 0, then wiper 1, then 0xFF for every further byte, for as long as the master acknowledges. Any change the slave makes on SDA waits a set number of system clocks after SCL falls, so the line holds for at least 300 ns.

Top module: `dualwiper_slave`

## Requirements
- R1: After reset both wipers read 0x00 and sda_oe is 0 (SDA released).
- R2: The slave responds only in a transfer opened by START (SDA falling while SCL high). After STOP (SDA rising while SCL high) it does not acknowledge bytes until the next START.
- R3: The slave acknowledges a control byte only if bits 7..4 are 0101 and bits 3..1 equal the current synchronized address pins; bit 0 is 1 for read, 0 for write. A change of the pins takes effect for the next control byte.
- R4: When addressed, the slave holds SDA low through the high phase of the ninth SCL pulse after each byte it accepts.
- R5: Command 0xA9 loads the first data byte into wiper 0 and an optional second data byte into wiper 1.
- R6: Command 0xAA loads the first data byte into wiper 1 only; wiper 0 is unchanged.
- R7: Command 0xAF loads the first data byte into both wipers.
- R8: Any other command byte is not acknowledged and changes no wiper. Bytes that follow it are not acknowledged until the next START.
- R9: Write data bytes beyond those the command uses are acknowledged and change no wiper.
- R10: A read returns wiper 0, then wiper 1, then 0xFF for each further byte, MSB first. The next byte is sent only after a master acknowledge. After a master not-acknowledge, SDA is released.
- R11: A repeated START with no STOP before it begins a new transfer with a fresh control byte.
- R12: A START or STOP within a byte ends the transfer. A partly received byte is dropped, and wiper values written earlier in that transfer are kept.
- R13: sda_oe does not change within HOLD_CYC system clocks after a synchronized SCL fall (default 38 cycles, 304 ns at 125 MHz).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Serial clock from the bus (asynchronous) |
| sda_in | input | 1 | Serial data level seen on the bus (asynchronous) |
| addr_pins | input | 3 | Device select pins, compared with control byte bits 3..1 |
| sda_oe | output | 1 | 1 pulls the open-drain SDA pad low |
| wiper0 | output | 8 | Wiper 0 position register |
| wiper1 | output | 8 | Wiper 1 position register |

## Verification
Two functions can fall in the same cycle. One is committing a received data byte into a wiper. The other is the acknowledge answer for that byte together with the abort logic that a later START or STOP triggers. The bench provokes this by ending a byte on a good data byte, then breaking off the next byte with a START or STOP partway through. Success means the committed value is still on the wiper port and the fresh transfer is decoded as normal. A second overlap is the hold timer against the master's next bit: the bench samples sda_oe shortly after each SCL fall around an acknowledge and requires the value from before the fall.

// File: rtl/dualwiper_pkg.sv
// Shared constants, state type and command decode for the dual wiper slave.
// Assumes an 8-bit byte and a 4-bit device code in front of the select bits.
package dualwiper_pkg;
    localparam int BYTE_W = 8;
    localparam logic [3:0] DEV_CODE = 4'b0101;
    localparam logic [7:0] CMD_W0   = 8'hA9;
    localparam logic [7:0] CMD_W1   = 8'hAA;
    localparam logic [7:0] CMD_BOTH = 8'hAF;
    localparam logic [7:0] RD_FILL  = 8'hFF;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_RX,
        LK_ACK,
        LK_TX,
        LK_MACK
    } link_state_t;

    function automatic logic cmd_known(input logic [BYTE_W-1:0] c);
        return (c == CMD_W0) || (c == CMD_W1) || (c == CMD_BOTH);
    endfunction
endpackage

// File: rtl/dw_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes STAGES >= 2; each bit has its own chain and a reset level from INIT.
module dw_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] INIT = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        // shift the raw input through the flop chain
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{INIT[g]}};
            else        chain <= {chain[STAGES-2:0], d[g]};
        end
        assign q[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/dw_regs.sv
// Wiper register pair with command decode and read-byte select.
// Assumes byte_idx 0 is the command byte, 1 and 2 the data bytes, 3 any later byte.
// A command of index 0 only arrives here when the link already accepted it.
module dw_regs
    import dualwiper_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_stb,
    input  logic [BYTE_W-1:0] byte_val,
    input  logic [1:0]        byte_idx,
    input  logic [1:0]        rd_idx,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [BYTE_W-1:0] wiper0,
    output logic [BYTE_W-1:0] wiper1
);
    logic [BYTE_W-1:0] cmd_q;

    // latch the command and steer data bytes into the wipers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            wiper0 <= '0;
            wiper1 <= '0;
        end else if (byte_stb) begin
            case (byte_idx)
                2'd0: cmd_q <= byte_val;
                2'd1: begin
                    if (cmd_q == CMD_W0 || cmd_q == CMD_BOTH) wiper0 <= byte_val;
                    if (cmd_q == CMD_W1 || cmd_q == CMD_BOTH) wiper1 <= byte_val;
                end
                2'd2: if (cmd_q == CMD_W0) wiper1 <= byte_val;
                default: ;
            endcase
        end
    end

    // pick the byte returned for the current read slot
    always_comb begin
        case (rd_idx)
            2'd0:    rd_byte = wiper0;
            2'd1:    rd_byte = wiper1;
            default: rd_byte = RD_FILL;
        endcase
    end

    // R9
    discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && byte_idx == 2'd3) |=> ($stable(wiper0) && $stable(wiper1)));
    // R6
    w1_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && byte_idx == 2'd1 && cmd_q == CMD_W1) |=> $stable(wiper0));
    // R12
    no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_stb |=> ($stable(wiper0) && $stable(wiper1)));
endmodule

// File: rtl/dw_link.sv
// Bit and byte engine of the two-wire slave: edge and START/STOP detection,
// control byte match, acknowledge, write byte strobes and read shifting.
// Assumes synchronized SCL/SDA; sda_oe changes only HOLD_CYC clocks after SCL falls.
module dw_link
    import dualwiper_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int HOLD_CYC = 38
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_q,
    input  logic              sda_q,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              byte_stb,
    output logic [BYTE_W-1:0] byte_val,
    output logic [1:0]        byte_idx,
    output logic [1:0]        rd_idx,
    output logic              sda_oe
);
    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic [HW-1:0] HOLD_V = HW'(HOLD_CYC);

    link_state_t       state;
    logic              scl_d, sda_d;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic              is_ctrl, rw, mack_ok;
    logic [1:0]        wr_idx;
    logic [HW-1:0]     hold_cnt;
    logic              drive_req;
    logic              scl_rise, scl_fall, start_ev, stop_ev, byte_end, addr_hit;

    // keep the previous line levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_q;
            sda_d <= sda_q;
        end
    end

    assign scl_rise = scl_q & ~scl_d;
    assign scl_fall = ~scl_q & scl_d;
    assign start_ev = scl_q & scl_d & sda_d & ~sda_q;
    assign stop_ev  = scl_q & scl_d & ~sda_d & sda_q;
    assign byte_end = scl_fall && (bitcnt == 4'd8);
    assign addr_hit = (shreg[BYTE_W-1:1] == {DEV_CODE, addr_q});

    // protocol state machine advanced on bus events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= LK_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            is_ctrl  <= 1'b0;
            rw       <= 1'b0;
            mack_ok  <= 1'b0;
            wr_idx   <= '0;
            rd_idx   <= '0;
            byte_stb <= 1'b0;
            byte_val <= '0;
            byte_idx <= '0;
        end else begin
            byte_stb <= 1'b0;
            if (start_ev) begin
                state   <= LK_RX;
                bitcnt  <= '0;
                is_ctrl <= 1'b1;
            end else if (stop_ev) begin
                state <= LK_IDLE;
            end else begin
                case (state)
                    LK_RX: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_q};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (byte_end) begin
                            bitcnt <= '0;
                            if (is_ctrl) begin
                                is_ctrl <= 1'b0;
                                rw      <= shreg[0];
                                wr_idx  <= '0;
                                rd_idx  <= '0;
                                state   <= addr_hit ? LK_ACK : LK_IDLE;
                            end else begin
                                byte_stb <= (wr_idx != 2'd0) || cmd_known(shreg);
                                byte_val <= shreg;
                                byte_idx <= wr_idx;
                                if (wr_idx == 2'd0 && !cmd_known(shreg)) begin
                                    state <= LK_IDLE;
                                end else begin
                                    state <= LK_ACK;
                                    if (wr_idx != 2'd3) wr_idx <= wr_idx + 2'd1;
                                end
                            end
                        end
                    end
                    LK_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (rw) begin
                                state <= LK_TX;
                                shreg <= rd_byte;
                                if (rd_idx != 2'd2) rd_idx <= rd_idx + 2'd1;
                            end else begin
                                state <= LK_RX;
                            end
                        end
                    end
                    LK_TX: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (byte_end) begin
                            state  <= LK_MACK;
                            bitcnt <= '0;
                        end else if (scl_fall) begin
                            shreg <= {shreg[BYTE_W-2:0], 1'b1};
                        end
                    end
                    LK_MACK: begin
                        if (scl_rise) begin
                            mack_ok <= ~sda_q;
                        end else if (scl_fall) begin
                            if (mack_ok) begin
                                state <= LK_TX;
                                shreg <= rd_byte;
                                if (rd_idx != 2'd2) rd_idx <= rd_idx + 2'd1;
                            end else begin
                                state <= LK_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign drive_req = (state == LK_ACK) || (state == LK_TX && !shreg[BYTE_W-1]);

    // hold the pad enable for HOLD_CYC clocks after each SCL fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt <= '0;
            sda_oe   <= 1'b0;
        end else begin
            if (scl_fall)              hold_cnt <= HOLD_V;
            else if (hold_cnt != '0)   hold_cnt <= hold_cnt - 1'b1;
            if (hold_cnt == '0 && !scl_fall) sda_oe <= drive_req;
        end
    end

    // cycles since the last SCL fall, saturating, for the hold check
    logic [HW-1:0] since_fall;
    always_ff @(posedge clk) begin
        if (!rst_n)                  since_fall <= HOLD_V;
        else if (scl_fall)           since_fall <= '0;
        else if (since_fall != HOLD_V) since_fall <= since_fall + 1'b1;
    end

    // R13
    sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_fall < HOLD_V) |=> $stable(sda_oe));
    // R2
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (state == LK_IDLE));
    // R11
    start_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state == LK_RX && is_ctrl && bitcnt == 4'd0));
    // R3
    addr_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LK_RX && byte_end && is_ctrl && !addr_hit && !start_ev && !stop_ev)
        |=> (state == LK_IDLE));
    // R8
    bad_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LK_RX && byte_end && !is_ctrl && wr_idx == 2'd0 && !cmd_known(shreg)
         && !start_ev && !stop_ev) |=> (state == LK_IDLE && !byte_stb));
endmodule

// File: rtl/dualwiper_slave.sv
// Top of the dual wiper two-wire slave: input synchronizers, bus engine and
// wiper registers. Assumes an external open-drain pad driven low by sda_oe.
module dualwiper_slave
    import dualwiper_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 3,
    parameter int HOLD_CYC    = 38
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [ADDR_W-1:0] addr_pins,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] wiper0,
    output logic [BYTE_W-1:0] wiper1
);
    logic [1:0]        line_q;
    logic [ADDR_W-1:0] addr_q;
    logic              byte_stb;
    logic [BYTE_W-1:0] byte_val, rd_byte;
    logic [1:0]        byte_idx, rd_idx;

    dw_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .INIT(2'b11)) u_line_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(line_q));

    dw_sync #(.WIDTH(ADDR_W), .STAGES(SYNC_STAGES), .INIT('0)) u_addr_sync (
        .clk(clk), .rst_n(rst_n), .d(addr_pins), .q(addr_q));

    dw_link #(.ADDR_W(ADDR_W), .HOLD_CYC(HOLD_CYC)) u_link (
        .clk(clk), .rst_n(rst_n), .scl_q(line_q[1]), .sda_q(line_q[0]),
        .addr_q(addr_q), .rd_byte(rd_byte), .byte_stb(byte_stb),
        .byte_val(byte_val), .byte_idx(byte_idx), .rd_idx(rd_idx),
        .sda_oe(sda_oe));

    dw_regs u_regs (
        .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .byte_val(byte_val),
        .byte_idx(byte_idx), .rd_idx(rd_idx), .rd_byte(rd_byte),
        .wiper0(wiper0), .wiper1(wiper1));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (wiper0 == '0 && wiper1 == '0 && !sda_oe));
endmodule

// File: tb/tb_dualwiper_slave.sv
module tb_dualwiper_slave;
    localparam int Q = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [2:0] pins = 3'b000;
    logic sda_oe;
    logic [7:0] wiper0, wiper1;
    wire sda_bus = sda_m & ~sda_oe;

    int checks = 0;
    int errors = 0;
    logic early_oe, first_early, ack_early;

    always #4 clk = ~clk;

    dualwiper_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .addr_pins(pins), .sda_oe(sda_oe), .wiper0(wiper0), .wiper1(wiper1));

    // cmd, d0, d1, count, expected w0, expected w1, command acknowledged
    localparam logic [42:0] VEC [8] = '{
        {8'hA9, 8'h12, 8'h00, 2'd1, 8'h12, 8'h00, 1'b1},
        {8'hA9, 8'h34, 8'h56, 2'd2, 8'h34, 8'h56, 1'b1},
        {8'hAA, 8'h78, 8'h00, 2'd1, 8'h34, 8'h78, 1'b1},
        {8'hAF, 8'h9C, 8'h00, 2'd1, 8'h9C, 8'h9C, 1'b1},
        {8'hA9, 8'h01, 8'hFE, 2'd2, 8'h01, 8'hFE, 1'b1},
        {8'h55, 8'h77, 8'h00, 2'd1, 8'h01, 8'hFE, 1'b0},
        {8'hAA, 8'h00, 8'h00, 2'd1, 8'h01, 8'h00, 1'b1},
        {8'hAF, 8'hFF, 8'h00, 2'd1, 8'hFF, 8'hFF, 1'b1}
    };

    task automatic wait_c(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bit_cycle(input logic mb, output logic sb);
        wait_c(20);
        early_oe = sda_oe;
        wait_c(Q - 20);
        sda_m = mb;
        wait_c(Q);
        scl_m = 1'b1;
        wait_c(Q);
        sb = sda_bus;
        wait_c(Q);
        scl_m = 1'b0;
    endtask

    task automatic start_c();
        sda_m = 1'b1;
        wait_c(Q);
        scl_m = 1'b1;
        wait_c(Q);
        sda_m = 1'b0;
        wait_c(Q);
        scl_m = 1'b0;
    endtask

    task automatic stop_c();
        sda_m = 1'b0;
        wait_c(Q);
        scl_m = 1'b1;
        wait_c(Q);
        sda_m = 1'b1;
        wait_c(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(b[i], s);
            if (i == 7) first_early = early_oe;
        end
        bit_cycle(1'b1, s);
        ack_early = early_oe;
        ack = ~s;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'b1, s);
            b[i] = s;
        end
        bit_cycle(~mack, s);
    endtask

    task automatic bits_only(input logic [7:0] b, input int n);
        logic s;
        for (int i = 0; i < n; i++) bit_cycle(b[7 - i], s);
    endtask

    initial begin
        #1600000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] rb;
        string tag;
        wait_c(10);
        rst_n = 1'b1;
        wait_c(5);
        chk("R1 wiper0", wiper0, 8'h00);
        chk("R1 wiper1", wiper1, 8'h00);
        chk("R1 sda_oe", sda_oe, 1'b0);

        // address matching
        pins = 3'b011;
        wait_c(10);
        start_c(); send_byte(8'h50, a); chk("R3 wrong select", a, 1'b0); stop_c();
        start_c(); send_byte(8'h66, a); chk("R3 wrong code", a, 1'b0); stop_c();
        start_c(); send_byte(8'h56, a); chk("R3 match", a, 1'b1);
        chk("R4 ack low", a, 1'b1);
        chk("R13 hold before ack", ack_early, 1'b0);
        send_byte(8'hAA, a);
        chk("R13 hold after ack", first_early, 1'b1);
        send_byte(8'h00, a);
        stop_c();
        pins = 3'b110;
        wait_c(10);
        start_c(); send_byte(8'h5C, a); chk("R3 live pins", a, 1'b1); stop_c();

        // table of write transactions
        foreach (VEC[k]) begin
            logic [42:0] v;
            v = VEC[k];
            case (v[42:35])
                8'hA9:   tag = "R5";
                8'hAA:   tag = "R6";
                8'hAF:   tag = "R7";
                default: tag = "R8";
            endcase
            start_c();
            send_byte(8'h5C, a);
            send_byte(v[42:35], a);
            chk({tag, " cmd ack"}, a, v[0]);
            send_byte(v[34:27], a);
            chk({tag, " data ack"}, a, v[0]);
            if (v[18:17] == 2'd2) begin
                send_byte(v[26:19], a);
                chk({tag, " data2 ack"}, a, 1'b1);
            end
            stop_c();
            chk({tag, " wiper0"}, wiper0, v[16:9]);
            chk({tag, " wiper1"}, wiper1, v[8:1]);
        end

        // extra bytes acknowledged and dropped
        start_c(); send_byte(8'h5C, a); send_byte(8'hA9, a);
        send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a);
        chk("R9 extra ack", a, 1'b1);
        send_byte(8'h44, a);
        stop_c();
        chk("R9 wiper0", wiper0, 8'h11);
        chk("R9 wiper1", wiper1, 8'h22);

        // read stream
        start_c(); send_byte(8'h5C, a); send_byte(8'hA9, a);
        send_byte(8'h3C, a); send_byte(8'hC3, a); stop_c();
        start_c(); send_byte(8'h5D, a); chk("R10 read ctrl ack", a, 1'b1);
        recv_byte(1'b1, rb); chk("R10 first", rb, 8'h3C);
        recv_byte(1'b1, rb); chk("R10 second", rb, 8'h C3);
        recv_byte(1'b0, rb); chk("R10 fill", rb, 8'hFF);
        wait_c(2 * Q);
        chk("R10 released", sda_oe, 1'b0);
        stop_c();
        start_c(); send_byte(8'h5D, a);
        recv_byte(1'b0, rb); chk("R10 single", rb, 8'h3C);
        wait_c(2 * Q);
        chk("R10 released single", sda_oe, 1'b0);
        stop_c();

        // repeated START
        start_c(); send_byte(8'h5C, a); send_byte(8'hAA, a); send_byte(8'h44, a);
        start_c(); send_byte(8'h5D, a); chk("R11 restart ack", a, 1'b1);
        recv_byte(1'b1, rb); chk("R11 w0", rb, 8'h3C);
        recv_byte(1'b0, rb); chk("R11 w1", rb, 8'h44);
        stop_c();

        // aborts within a byte
        start_c(); send_byte(8'h5C, a); send_byte(8'hA9, a);
        bits_only(8'h99, 4);
        stop_c();
        chk("R12 stop abort", wiper0, 8'h3C);
        send_byte(8'h5C, a);
        chk("R2 no START", a, 1'b0);
        start_c(); send_byte(8'h5C, a); send_byte(8'hA9, a); send_byte(8'h5A, a);
        bits_only(8'hE7, 3);
        start_c(); send_byte(8'h5C, a); send_byte(8'hAA, a); send_byte(8'h66, a);
        chk("R12 new transfer ack", a, 1'b1);
        stop_c();
        chk("R12 kept wiper0", wiper0, 8'h5A);
        chk("R12 wiper1", wiper1, 8'h66);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule